// File: doc/BRIEF.md
# Multicycle Bus Processor

A compact processor that moves 16-bit words between eight general registers over one shared bus. Instructions are not fetched from memory: a controlling agent presents each instruction word on the data input while `run` is high, and the core works through it in two or four clock steps, raising `done` in its last step. A move-immediate instruction takes its data word from the same input one step after the instruction word.

Inside the core sit a 9-bit instruction register, eight data registers, an operand register that holds the first addend, and a result register that captures the adder/subtractor output. A control state machine walks through four named steps. In `ST_T0` it loads the instruction. In `ST_T1` it finishes a move, finishes a load-immediate, or stages the first operand. In `ST_T2` it drives the second operand and captures the sum or difference. In `ST_T3` it writes the result back. The transitions are: `ST_T0→ST_T1` on every running cycle. `ST_T1→ST_T0` when the step completes the instruction (move, load-immediate, unused opcode). `ST_T1→ST_T2` for add and subtract. `ST_T2→ST_T3` always. `ST_T3→ST_T0` always. With `run` low the machine holds its step, and reset sends it to `ST_T0`. The bus value is visible at a port; whenever no source is enabled it reads zero.

Top module: `bus_cpu`

## Requirements
- R1: In `ST_T0` the core captures `din[15:7]` as the instruction word: bits 8:6 are the opcode, bits 5:3 name the destination Rx, bits 2:0 name the source Ry. During that step no source drives the bus (bus reads 0) and `done` is low.
- R2: Opcode 000 (move) drives Ry onto the bus in `ST_T1`, writes it into Rx and raises `done` in that step.
- R3: Opcode 001 (load immediate) drives `din` as sampled in `ST_T1` onto the bus, writes it into Rx and raises `done` in that step.
- R4: Opcode 010 (add) drives Rx in `ST_T1`, Ry in `ST_T2`, and the result register in `ST_T3`, where Rx receives Rx+Ry modulo 2^16 and `done` is high.
- R5: Opcode 011 (subtract) follows the same three steps as R4 and writes Rx−Ry modulo 2^16.
- R6: The step that raises `done` returns the machine to `ST_T0`, so an instruction presented on the following cycle starts at once. `done` is low in every other step.
- R7: While `run` is low the step is held, no register is written, `done` is low and the bus reads 0. Execution resumes at the held step once `run` returns high.
- R8: A synchronous active-high `rst` returns the machine to `ST_T0`, keeps `done` low and the bus at 0 while asserted, and writes no data register, even when it falls in a `done` step.
- R9: Opcodes 100 to 111 raise `done` in `ST_T1` with the bus at 0 and write no register.
- R10: At most one bus source (a data register, `din`, or the result register) is enabled in any cycle.
- R11: When Rx and Ry name the same register, a move leaves it unchanged and an add doubles it modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Execute enable; low freezes the step |
| din | input | 16 | Instruction word in `ST_T0`, immediate data in `ST_T1` |
| done | output | 1 | High in the final step of each instruction |
| bus_out | output | 16 | Current value on the internal shared bus |

## Verification
Two functions can land in one cycle. One is a read and a write of the same register: in a move or add whose two selectors are equal, the destination drives the bus and loads from it at the same edge. The other is a reset that arrives in the very step that would write back. The first is provoked with `mv R3,R3` and `add R4,R4`, and is judged by the value on the bus in the `done` step and by reading the register back afterwards. The second asserts reset in the `ST_T3` step of an add and in the `ST_T1` step of a load-immediate, then moves the target register out to the bus to show that it kept its old value.

// File: rtl/bus_cpu_pkg.sv
package bus_cpu_pkg;

    localparam int OPC_W = 3;
    localparam int SEL_W = 3;
    localparam int INSN_W = OPC_W + 2 * SEL_W;

    localparam logic [OPC_W-1:0] OP_MOVE  = 3'd0;
    localparam logic [OPC_W-1:0] OP_LOADI = 3'd1;
    localparam logic [OPC_W-1:0] OP_ADD   = 3'd2;
    localparam logic [OPC_W-1:0] OP_SUB   = 3'd3;

    typedef enum logic [1:0] {
        ST_T0 = 2'd0,
        ST_T1 = 2'd1,
        ST_T2 = 2'd2,
        ST_T3 = 2'd3
    } step_t;

endpackage

// File: rtl/bus_cpu_ctrl.sv
module bus_cpu_ctrl
    import bus_cpu_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [INSN_W-1:0] insn_word,
    output logic [NREG-1:0]   reg_oe,
    output logic              din_oe,
    output logic              g_oe,
    output logic [NREG-1:0]   reg_we,
    output logic              a_load,
    output logic              g_load,
    output logic              sub_mode,
    output logic              done
);

    step_t             step_q;
    step_t             step_nxt;
    logic [INSN_W-1:0] ir_q;
    logic              ir_load;

    logic [OPC_W-1:0]  opc;
    logic [SEL_W-1:0]  rx_sel;
    logic [SEL_W-1:0]  ry_sel;
    logic              is_arith;
    logic [NREG-1:0]   rx_hot;
    logic [NREG-1:0]   ry_hot;

    assign opc      = ir_q[INSN_W-1 -: OPC_W];
    assign rx_sel   = ir_q[2*SEL_W-1 -: SEL_W];
    assign ry_sel   = ir_q[SEL_W-1:0];
    assign is_arith = (opc == OP_ADD) || (opc == OP_SUB);
    assign rx_hot   = NREG'(1) << rx_sel;
    assign ry_hot   = NREG'(1) << ry_sel;

    // step register
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_T0;
        end else begin
            step_q <= step_nxt;
        end
    end

    // instruction register
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (ir_load) begin
            ir_q <= insn_word;
        end
    end

    // next step: hold when stopped, clear on completion
    always_comb begin
        step_nxt = step_q;
        if (run) begin
            if (done) begin
                step_nxt = ST_T0;
            end else begin
                unique case (step_q)
                    ST_T0: step_nxt = ST_T1;
                    ST_T1: step_nxt = ST_T2;
                    ST_T2: step_nxt = ST_T3;
                    ST_T3: step_nxt = ST_T0;
                endcase
            end
        end
    end

    // control outputs per step
    always_comb begin
        ir_load  = 1'b0;
        reg_oe   = '0;
        din_oe   = 1'b0;
        g_oe     = 1'b0;
        reg_we   = '0;
        a_load   = 1'b0;
        g_load   = 1'b0;
        sub_mode = 1'b0;
        done     = 1'b0;
        if (run && !rst) begin
            unique case (step_q)
                ST_T0: begin
                    ir_load = 1'b1;
                end
                ST_T1: begin
                    if (opc == OP_MOVE) begin
                        reg_oe = ry_hot;
                        reg_we = rx_hot;
                        done   = 1'b1;
                    end else if (opc == OP_LOADI) begin
                        din_oe = 1'b1;
                        reg_we = rx_hot;
                        done   = 1'b1;
                    end else if (is_arith) begin
                        reg_oe = rx_hot;
                        a_load = 1'b1;
                    end else begin
                        done   = 1'b1;
                    end
                end
                ST_T2: begin
                    if (is_arith) begin
                        reg_oe   = ry_hot;
                        g_load   = 1'b1;
                        sub_mode = (opc == OP_SUB);
                    end
                end
                ST_T3: begin
                    if (is_arith) begin
                        g_oe   = 1'b1;
                        reg_we = rx_hot;
                        done   = 1'b1;
                    end
                end
            endcase
        end
    end

    assert_clear_after_done_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> (step_q == ST_T0));

    assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(step_q));

    assert_reset_to_t0_R8: assert property (@(posedge clk)
        rst |=> (step_q == ST_T0));

    assert_one_source_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_oe, din_oe, g_oe}));

    assert_arith_order_R4: assert property (@(posedge clk) disable iff (rst)
        (g_load && run) |=> (step_q == ST_T3));

endmodule

// File: rtl/bus_cpu_regfile.sv
module bus_cpu_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREG-1:0]  we,
    input  logic [DW-1:0]    wdata,
    output logic [NREG*DW-1:0] rdata_flat
);

    logic [DW-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (we[i]) begin
                regs_q[i] <= wdata;
            end
        end
        assign rdata_flat[i*DW +: DW] = regs_q[i];
    end

    assert_single_dest_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

    assert_no_write_in_reset_R8: assert property (@(posedge clk)
        rst |-> (we == '0));

endmodule

// File: rtl/bus_cpu_mux.sv
module bus_cpu_mux #(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic [NREG*DW-1:0] regs_flat,
    input  logic [DW-1:0]      din,
    input  logic [DW-1:0]      g_val,
    input  logic [NREG-1:0]    reg_oe,
    input  logic               din_oe,
    input  logic               g_oe,
    output logic [DW-1:0]      bus
);

    logic [DW-1:0] masked [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_mask
        assign masked[i] = regs_flat[i*DW +: DW] & {DW{reg_oe[i]}};
    end

    always_comb begin
        bus = (din & {DW{din_oe}}) | (g_val & {DW{g_oe}});
        for (int i = 0; i < NREG; i++) begin
            bus = bus | masked[i];
        end
    end

endmodule

// File: rtl/bus_cpu_arith.sv
module bus_cpu_arith #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          a_load,
    input  logic          g_load,
    input  logic          sub_mode,
    input  logic [DW-1:0] bus,
    output logic [DW-1:0] g_q
);

    logic [DW-1:0] a_q;
    logic [DW-1:0] result;

    assign result = sub_mode ? (a_q - bus) : (a_q + bus);

    always_ff @(posedge clk) begin
        if (a_load) begin
            a_q <= bus;
        end
    end

    always_ff @(posedge clk) begin
        if (g_load) begin
            g_q <= result;
        end
    end

endmodule

// File: rtl/bus_cpu.sv
module bus_cpu
    import bus_cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] din,
    output logic          done,
    output logic [DW-1:0] bus_out
);

    localparam int NREG = 2 ** SEL_W;

    logic [NREG-1:0]    reg_oe;
    logic [NREG-1:0]    reg_we;
    logic               din_oe;
    logic               g_oe;
    logic               a_load;
    logic               g_load;
    logic               sub_mode;
    logic [NREG*DW-1:0] regs_flat;
    logic [DW-1:0]      g_val;
    logic [DW-1:0]      bus;

    bus_cpu_ctrl #(.NREG(NREG)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .insn_word(din[DW-1 -: INSN_W]),
        .reg_oe   (reg_oe),
        .din_oe   (din_oe),
        .g_oe     (g_oe),
        .reg_we   (reg_we),
        .a_load   (a_load),
        .g_load   (g_load),
        .sub_mode (sub_mode),
        .done     (done)
    );

    bus_cpu_regfile #(.DW(DW), .NREG(NREG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .wdata     (bus),
        .rdata_flat(regs_flat)
    );

    bus_cpu_mux #(.DW(DW), .NREG(NREG)) u_mux (
        .regs_flat(regs_flat),
        .din      (din),
        .g_val    (g_val),
        .reg_oe   (reg_oe),
        .din_oe   (din_oe),
        .g_oe     (g_oe),
        .bus      (bus)
    );

    bus_cpu_arith #(.DW(DW)) u_arith (
        .clk     (clk),
        .a_load  (a_load),
        .g_load  (g_load),
        .sub_mode(sub_mode),
        .bus     (bus),
        .g_q     (g_val)
    );

    assign bus_out = bus;

    assert_idle_in_reset_R8: assert property (@(posedge clk)
        rst |-> (!done && bus == '0));

    assert_no_writeback_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        !run |-> (reg_we == '0 && !done));

endmodule

// File: tb/bus_cpu_tb.sv
module bus_cpu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] din = '0;
    logic        done;
    logic [15:0] bus_out;

    int total = 0;
    int bad   = 0;

    logic [15:0] mdl [8];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    bus_cpu u_dut (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .din    (din),
        .done   (done),
        .bus_out(bus_out)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one instruction, optional stall or reset at a given step
    task automatic exec(input logic [2:0] op, input int x, input int y, input logic [15:0] data,
                        input string tag, input int stall_at = -1, input int rst_at = -1);
        bit          arith = (op == 3'd2) || (op == 3'd3);
        int          nsteps = arith ? 4 : 2;
        logic [15:0] expv;
        for (int s = 0; s < nsteps; s++) begin
            @(negedge clk);
            din = (s == 0) ? {op, x[2:0], y[2:0], 7'b0} : data;
            if (stall_at == s) begin
                run = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    #1;
                    check(done == 1'b0, "R7 done low while stopped", {15'b0, done}, 16'h0);
                    check(bus_out == 16'h0, "R7 bus idle while stopped", bus_out, 16'h0);
                    @(negedge clk);
                end
            end
            run = 1'b1;
            if (rst_at == s) begin
                rst = 1'b1;
                #1;
                check(done == 1'b0, "R8 done low in reset", {15'b0, done}, 16'h0);
                check(bus_out == 16'h0, "R8 bus idle in reset", bus_out, 16'h0);
                @(negedge clk);
                rst = 1'b0;
                run = 1'b0;
                return;
            end
            if (s == nsteps - 1) begin
                case (op)
                    3'd0: expv = mdl[y];
                    3'd1: expv = data;
                    3'd2: expv = mdl[x] + mdl[y];
                    3'd3: expv = mdl[x] - mdl[y];
                    default: expv = 16'h0;
                endcase
                exp_q.push_back(expv);
                tag_q.push_back(tag);
                if (op <= 3'd3) mdl[x] = expv;
                #1;
                check(done == 1'b1, "R6 done in final step", {15'b0, done}, 16'h1);
            end else begin
                #1;
                check(done == 1'b0, "R6 done low before final step", {15'b0, done}, 16'h0);
                if (s == 0) check(bus_out == 16'h0, "R1 bus idle in T0", bus_out, 16'h0);
                if (arith && s == 1) check(bus_out == mdl[x], "R4 Rx on bus in T1", bus_out, mdl[x]);
                if (arith && s == 2) check(bus_out == mdl[y], "R4 Ry on bus in T2", bus_out, mdl[y]);
            end
        end
    endtask

    // monitor: compares bus value at each done against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", bus_out, 16'h0);
                end else begin
                    logic [15:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bus_out == e, t, bus_out, e);
                end
            end
        end
    end

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(done == 1'b0, "R8 done low at reset", {15'b0, done}, 16'h0);
        check(bus_out == 16'h0, "R8 bus idle at reset", bus_out, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        // R3: load all registers with immediates
        for (int i = 0; i < 7; i++) begin
            exec(3'd1, i, 0, 16'h1234 + 16'(i) * 16'h1111, "R3 load immediate");
        end
        exec(3'd1, 7, 0, 16'hFFFF, "R3 load immediate all ones");

        // R2: register moves
        exec(3'd0, 2, 5, 16'h0, "R2 move R5 to R2");
        exec(3'd0, 6, 2, 16'h0, "R2 move R2 to R6");

        // R4: add with wrap
        exec(3'd2, 0, 7, 16'h0, "R4 add wraps");
        exec(3'd2, 3, 1, 16'h0, "R4 add");

        // R5: subtract with wrap below zero
        exec(3'd3, 1, 4, 16'h0, "R5 sub wraps");
        exec(3'd3, 4, 0, 16'h0, "R5 sub");

        // R11: same register as source and destination
        exec(3'd0, 3, 3, 16'h0, "R11 move to self");
        exec(3'd0, 5, 3, 16'h0, "R11 readback after self move");
        exec(3'd2, 4, 4, 16'h0, "R11 add to self doubles");

        // R9: unused opcodes write nothing
        exec(3'd5, 2, 1, 16'h0, "R9 unused opcode bus idle");
        exec(3'd7, 6, 6, 16'h0, "R9 unused opcode bus idle");
        exec(3'd0, 0, 2, 16'h0, "R9 R2 untouched");
        exec(3'd0, 1, 6, 16'h0, "R9 R6 untouched");

        // R7: stalls at several steps
        exec(3'd2, 5, 6, 16'h0, "R7 add with stall in T1", 1);
        exec(3'd3, 6, 5, 16'h0, "R7 sub with stall in T2", 2);
        exec(3'd1, 7, 0, 16'hA5C3, "R7 load with stall in T1", 1);
        exec(3'd0, 2, 7, 16'h0, "R7 move with stall in T0", 0);

        // R8: reset in the write-back step
        exec(3'd2, 0, 1, 16'h0, "R8 aborted add", -1, 3);
        exec(3'd0, 3, 0, 16'h0, "R8 R0 kept after abort");
        exec(3'd1, 5, 0, 16'h7777, "R8 aborted load", -1, 1);
        exec(3'd0, 4, 5, 16'h0, "R8 R5 kept after abort");

        // R6: read back every register with continuous run
        for (int i = 0; i < 8; i++) begin
            exec(3'd0, i, i, 16'h0, "R6 back-to-back readback");
        end

        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all results seen", 16'(exp_q.size()), 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule